// File: doc/BRIEF.md
# Two-dimensional DMA address generator

This block produces the word addresses for one channel of a rectangular memory transfer. Software sets a start word address, a line length, a line stride and a line count, then pulses `start`. The engine then walks the line word by word. At the end of each line it jumps to the previous line start plus the stride. After the last word of the last line it raises a one-cycle `done` and goes idle. The data path accepts each offered address by asserting `advance` while `beat_valid` is high. The address moves only on such an accepted beat.

A line length of zero selects ring mode. The address then counts upward through an area of `stride * (line count + 1)` words. After the last word of the area it returns to the start address, and it never completes. The area is split into two equal halves, and a one-cycle event marks the end of each half, so a consumer can use the ring as a ping-pong buffer. A `stop` input ends either mode at once, with no `done`.

All quantities are 32-bit word units. The address port carries the byte address shifted right by two.

Top module: `dma2d_gen`

## Requirements
- R1: While `rst_n` is low and after reset, `beat_valid`, `done`, `ring_mid` and `ring_end` are 0, and `addr` is 0.
- R2: A `start` pulse while idle captures all `cfg_*` inputs. In the next cycle `beat_valid` is 1 and `addr` equals `cfg_base`.
- R3: Within a line, each accepted beat (`beat_valid` and `advance` high, `stop` low) raises `addr` by 1 in the next cycle. A cycle with `advance` low leaves `addr` unchanged.
- R4: In normal mode (`cfg_xlen` not 0), `cfg_xlen` is the number of words per line and `cfg_ylen` is the number of lines minus one. Accepting the last word of a line that is not the final line moves `addr` to that line's start address plus `cfg_stride`.
- R5: In normal mode, accepting the last word of the final line makes `done` 1 for exactly one cycle, the next cycle. In that same cycle `beat_valid` falls to 0, and `addr` keeps the last word's address.
- R6: With `cfg_xlen` = 0 (ring mode), `addr` steps through `cfg_base` to `cfg_base + A - 1`, where A = `cfg_stride * (cfg_ylen + 1)`. After that it returns to `cfg_base`, and `done` never rises. A must be even and at least 2.
- R7: In ring mode, `ring_mid` pulses for one cycle after the beat at offset A/2-1 is accepted, and `ring_end` after the beat at offset A-1. Neither pulses in normal mode.
- R8: `stop` while busy ends the walk. In the next cycle `beat_valid` is 0 and `done` is 0, and a beat offered in the stop cycle is not accepted, so `addr` is unchanged.
- R9: `start` while busy has no effect. The walk continues with its captured parameters.
- R10: While idle and without `start`, `addr` holds its last value whatever the `cfg_*` inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | AW | Start word address |
| cfg_xlen | input | XW | Words per line; 0 selects ring mode |
| cfg_stride | input | SW | Line stride in words (line length plus gap) |
| cfg_ylen | input | YW | Number of lines minus one |
| start | input | 1 | Launch pulse, honoured only when idle |
| stop | input | 1 | Abort the current walk |
| advance | input | 1 | Data path accepts the offered beat |
| addr | output | AW | Current word address |
| beat_valid | output | 1 | An address is on offer (engine busy) |
| done | output | 1 | One-cycle normal-mode completion pulse |
| ring_mid | output | 1 | One-cycle pulse at the end of the first ring half |
| ring_end | output | 1 | One-cycle pulse at the end of the second ring half |

## Verification
The hardest behaviour to reach from the ports is the ring wrap: the return to the start address and the two half events at their exact boundary beats, with the walk still running and `done` staying low. The stimulus uses a small eight-word ring and keeps it running past two full wraps, checking the offset of every beat. It then stops the ring in the middle of the area. The normal-mode runs use stalls and a one-word-per-line shape, so that each line jump and the final-beat pulse land on distinct, predictable cycles.

// File: rtl/dma2d_pkg.sv
// Shared types of the two-dimensional address generator.
package dma2d_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dma2d_state_t;
endpackage

// File: rtl/dma2d_ctrl.sv
// Run/idle sequencer. Accepts a start only while idle, leaves the run state
// on stop or on the final normal-mode beat, and issues the done pulse.
// Assumes acc is already qualified with run and with stop low.
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic acc,
    input  logic last_word,
    input  logic loop_mode,
    output logic run,
    output logic load,
    output logic done
);
    dma2d_state_t state_q;

    // Start is honoured only from idle.
    assign load = (state_q == ST_IDLE) && start;
    assign run  = (state_q == ST_RUN);

    // State transitions and the registered completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) state_q <= ST_RUN;
                ST_RUN: begin
                    if (stop) begin
                        state_q <= ST_IDLE;
                    end else if (acc && last_word && !loop_mode) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma2d_walk.sv
// Normal-mode walker: word counter within a line, line counter, and the
// running line-start address. Assumes xlen >= 1 while it is being driven.
module dma2d_walk #(
    parameter int AW = 30,
    parameter int XW = 12,
    parameter int SW = 14,
    parameter int YW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic          acc,
    input  logic [XW-1:0] xlen,
    input  logic [SW-1:0] stride,
    input  logic [YW-1:0] ylen,
    output logic [AW-1:0] addr,
    output logic          last_word
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] line_q;
    logic [XW-1:0] xcnt_q;
    logic [YW-1:0] ycnt_q;
    logic          line_end;
    logic [AW-1:0] next_line;

    // End-of-line and end-of-transfer detection.
    assign line_end  = (xcnt_q == xlen - XW'(1));
    assign last_word = line_end && (ycnt_q == ylen);
    assign next_line = line_q + AW'(stride);
    assign addr      = addr_q;

    // Address and counter update on load or on an accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            line_q <= '0;
            xcnt_q <= '0;
            ycnt_q <= '0;
        end else if (load) begin
            addr_q <= base_in;
            line_q <= base_in;
            xcnt_q <= '0;
            ycnt_q <= '0;
        end else if (acc) begin
            if (line_end) begin
                if (!last_word) begin
                    line_q <= next_line;
                    addr_q <= next_line;
                    xcnt_q <= '0;
                    ycnt_q <= ycnt_q + YW'(1);
                end
            end else begin
                addr_q <= addr_q + AW'(1);
                xcnt_q <= xcnt_q + XW'(1);
            end
        end
    end
endmodule

// File: rtl/dma2d_ring.sv
// Ring-mode walker: linear offset over an area of 'area' words, wrapping to
// the start address, with registered half and full boundary events.
// Assumes area is even and at least 2.
module dma2d_ring #(
    parameter int AW = 30,
    parameter int PW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_in,
    input  logic [AW-1:0] base_hold,
    input  logic          acc,
    input  logic [PW-1:0] area,
    output logic [AW-1:0] addr,
    output logic          mid,
    output logic          fin
);
    logic [AW-1:0] addr_q;
    logic [PW-1:0] pos_q;
    logic          at_end;
    logic          at_half;

    // Boundary offsets of the two halves.
    assign at_end  = (pos_q == area - PW'(1));
    assign at_half = (pos_q == (area >> 1) - PW'(1));
    assign addr    = addr_q;

    // Offset and address update, wrap, and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pos_q  <= '0;
            mid    <= 1'b0;
            fin    <= 1'b0;
        end else begin
            mid <= acc && at_half;
            fin <= acc && at_end;
            if (load) begin
                addr_q <= base_in;
                pos_q  <= '0;
            end else if (acc) begin
                if (at_end) begin
                    addr_q <= base_hold;
                    pos_q  <= '0;
                end else begin
                    addr_q <= addr_q + AW'(1);
                    pos_q  <= pos_q + PW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/dma2d_gen.sv
// Two-dimensional DMA address generator top. Captures the configuration at
// start, and routes accepted beats to the normal walker or the ring walker
// by the captured mode. Assumes the data path holds advance only as a
// response to beat_valid.
module dma2d_gen #(
    parameter int AW = 30,
    parameter int XW = 12,
    parameter int SW = 14,
    parameter int YW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [XW-1:0] cfg_xlen,
    input  logic [SW-1:0] cfg_stride,
    input  logic [YW-1:0] cfg_ylen,
    input  logic          start,
    input  logic          stop,
    input  logic          advance,
    output logic [AW-1:0] addr,
    output logic          beat_valid,
    output logic          done,
    output logic          ring_mid,
    output logic          ring_end
);
    localparam int PW = SW + YW;

    logic          run;
    logic          load;
    logic          acc;
    logic          last_word;
    logic          loop_q;
    logic [AW-1:0] base_q;
    logic [XW-1:0] xlen_q;
    logic [SW-1:0] stride_q;
    logic [YW-1:0] ylen_q;
    logic [PW-1:0] area;
    logic [AW-1:0] walk_addr;
    logic [AW-1:0] ring_addr;

    // Accepted beat: offered, taken, and not aborted.
    assign acc  = run && advance && !stop;
    assign area = PW'(stride_q) * (PW'(ylen_q) + PW'(1));

    // Configuration capture at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            xlen_q   <= '0;
            stride_q <= '0;
            ylen_q   <= '0;
            loop_q   <= 1'b0;
        end else if (load) begin
            base_q   <= cfg_base;
            xlen_q   <= cfg_xlen;
            stride_q <= cfg_stride;
            ylen_q   <= cfg_ylen;
            loop_q   <= (cfg_xlen == '0);
        end
    end

    dma2d_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .acc       (acc),
        .last_word (last_word),
        .loop_mode (loop_q),
        .run       (run),
        .load      (load),
        .done      (done)
    );

    dma2d_walk #(.AW(AW), .XW(XW), .SW(SW), .YW(YW)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base_in   (cfg_base),
        .acc       (acc && !loop_q),
        .xlen      (xlen_q),
        .stride    (stride_q),
        .ylen      (ylen_q),
        .addr      (walk_addr),
        .last_word (last_word)
    );

    dma2d_ring #(.AW(AW), .PW(PW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base_in   (cfg_base),
        .base_hold (base_q),
        .acc       (acc && loop_q),
        .area      (area),
        .addr      (ring_addr),
        .mid       (ring_mid),
        .fin       (ring_end)
    );

    // Output selection by the captured mode.
    assign addr       = loop_q ? ring_addr : walk_addr;
    assign beat_valid = run;
endmodule

// File: rtl/dma2d_chk.sv
// Property checker for dma2d_gen, attached by bind. Observes ports and the
// captured mode flag only.
module dma2d_chk #(
    parameter int AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          stop,
    input logic          advance,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] addr,
    input logic          beat_valid,
    input logic          done,
    input logic          ring_mid,
    input logic          ring_end,
    input logic          loop_q
);
    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && start) |=> (beat_valid && addr == $past(cfg_base))); // R2
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !advance) |=> $stable(addr)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !beat_valid); // R5
    AST_RING_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && loop_q) |=> !done); // R6
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_mid && ring_end)); // R7
    AST_EVT_RING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_mid || ring_end) |-> loop_q); // R7
    AST_STOP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && stop) |=> (!beat_valid && !done && $stable(addr))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat_valid && !start) |=> $stable(addr)); // R10
endmodule

bind dma2d_gen dma2d_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .advance    (advance),
    .cfg_base   (cfg_base),
    .addr       (addr),
    .beat_valid (beat_valid),
    .done       (done),
    .ring_mid   (ring_mid),
    .ring_end   (ring_end),
    .loop_q     (loop_q)
);

// File: tb/dma2d_gen_tb.sv
// Directed bench for dma2d_gen: one task per scenario, inputs driven and
// outputs sampled at the falling edge.
module dma2d_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;
    localparam int XW = 12;
    localparam int SW = 14;
    localparam int YW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic [XW-1:0] cfg_xlen = '0;
    logic [SW-1:0] cfg_stride = '0;
    logic [YW-1:0] cfg_ylen = '0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic          advance = 1'b0;
    logic [AW-1:0] addr;
    logic          beat_valid;
    logic          done;
    logic          ring_mid;
    logic          ring_end;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma2d_gen #(.AW(AW), .XW(XW), .SW(SW), .YW(YW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .cfg_xlen   (cfg_xlen),
        .cfg_stride (cfg_stride),
        .cfg_ylen   (cfg_ylen),
        .start      (start),
        .stop       (stop),
        .advance    (advance),
        .addr       (addr),
        .beat_valid (beat_valid),
        .done       (done),
        .ring_mid   (ring_mid),
        .ring_end   (ring_end)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // R1: outputs during and right after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(beat_valid == 1'b0, "R1 beat_valid in reset", beat_valid, 0);
        chk(done == 1'b0 && ring_mid == 1'b0 && ring_end == 1'b0, "R1 pulses in reset",
            {done, ring_mid, ring_end}, 0);
        chk(addr == '0, "R1 addr in reset", addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(beat_valid == 1'b0 && addr == '0, "R1 after reset", addr, 0);
    endtask

    // R2-R5, R9, R10: normal-mode walk with optional stalls and a busy start.
    task automatic t_normal(input int b, input int xl, input int st, input int yl,
                            input bit stall, input bit poke);
        int exp;
        int k;
        int last;
        k = 0;
        last = b + yl * st + xl - 1;
        @(negedge clk);
        cfg_base = AW'(b); cfg_xlen = XW'(xl); cfg_stride = SW'(st); cfg_ylen = YW'(yl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int y = 0; y <= yl; y++) begin
            for (int x = 0; x < xl; x++) begin
                exp = b + y * st + x;
                if (k == 0)
                    chk(beat_valid && addr == AW'(exp), "R2 first addr", addr, exp);
                else if (x == 0)
                    chk(beat_valid && addr == AW'(exp), "R4 line start", addr, exp);
                else
                    chk(beat_valid && addr == AW'(exp), "R3 in-line addr", addr, exp);
                if (poke && k == 2)
                    chk(addr == AW'(exp), "R9 busy start ignored", addr, exp);
                chk(done == 1'b0, "R5 no early done", done, 0);
                if (stall && (k % 2 == 1)) begin
                    advance = 1'b0;
                    @(negedge clk);
                    chk(addr == AW'(exp), "R3 stall hold", addr, exp);
                end
                if (poke && k == 1) begin
                    start = 1'b1;
                    cfg_base = AW'(b + 500);
                    cfg_xlen = '0;
                end
                advance = 1'b1;
                @(negedge clk);
                advance = 1'b0;
                start = 1'b0;
                k++;
            end
        end
        chk(done == 1'b1, "R5 done pulse", done, 1);
        chk(beat_valid == 1'b0, "R5 idle at done", beat_valid, 0);
        chk(addr == AW'(last), "R5 addr holds last", addr, last);
        cfg_base = AW'(b + 1234);
        cfg_xlen = XW'(2);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
        repeat (2) @(negedge clk);
        chk(addr == AW'(last) && beat_valid == 1'b0, "R10 idle hold", addr, last);
    endtask

    // R6, R7, R8: ring walk over two wraps, then stop mid-area.
    task automatic t_ring();
        int b;
        int area;
        int off;
        b = 200;
        area = 8;
        @(negedge clk);
        cfg_base = AW'(b); cfg_xlen = '0; cfg_stride = SW'(4); cfg_ylen = YW'(1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 19; i++) begin
            off = i % area;
            chk(beat_valid && addr == AW'(b + off), "R6 ring addr", addr, b + off);
            advance = 1'b1;
            @(negedge clk);
            advance = 1'b0;
            chk(ring_mid == (off == area / 2 - 1), "R7 ring_mid", ring_mid, off == area / 2 - 1);
            chk(ring_end == (off == area - 1), "R7 ring_end", ring_end, off == area - 1);
            chk(done == 1'b0, "R6 no done in ring", done, 0);
        end
        off = 19 % area;
        chk(addr == AW'(b + off), "R6 ring addr before stop", addr, b + off);
        stop = 1'b1;
        advance = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        advance = 1'b0;
        chk(beat_valid == 1'b0, "R8 stop ends ring", beat_valid, 0);
        chk(addr == AW'(b + off), "R8 stop beat not taken", addr, b + off);
        chk(done == 1'b0 && ring_mid == 1'b0 && ring_end == 1'b0, "R8 no pulse on stop",
            {done, ring_mid, ring_end}, 0);
    endtask

    // R8: stop during a normal walk.
    task automatic t_stop();
        @(negedge clk);
        cfg_base = AW'(300); cfg_xlen = XW'(4); cfg_stride = SW'(8); cfg_ylen = YW'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        advance = 1'b1;
        repeat (2) @(negedge clk);
        advance = 1'b0;
        chk(addr == AW'(302), "R3 before stop", addr, 302);
        stop = 1'b1;
        advance = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        advance = 1'b0;
        chk(beat_valid == 1'b0 && done == 1'b0, "R8 abort normal", {beat_valid, done}, 0);
        chk(addr == AW'(302), "R8 addr after stop", addr, 302);
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && addr == AW'(302), "R8 no late done", done, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_normal(100, 3, 5, 2, 1'b0, 1'b0);
        t_normal(400, 4, 6, 1, 1'b1, 1'b0);
        t_normal(50, 1, 3, 0, 1'b0, 1'b0);
        t_normal(700, 1, 7, 3, 1'b0, 1'b1);
        t_ring();
        t_stop();
        t_normal(900, 2, 2, 2, 1'b1, 1'b1);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule